// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog peripheral that counts down a 16-bit value and raises a reset pulse, an interrupt, or both when the count runs out. Software programs it through a small single-cycle register port with three locations: a control word, a reload value and the live count. The time base comes from the input clock. It is divided first by a programmable 8-bit prescaler (1 to 256) and then by a fixed divider chosen from 16, 32, 64 or 128.

While software is healthy it rewrites the count location at intervals. Each such write reloads the counter at once and restarts both dividers. If the rewrite does not come in time, the counter passes zero. The counter then reloads itself from the reload location and keeps running, and it raises each output whose enable is set. Clearing the enable bit freezes the count.

Top module: `wdt_top`

## Requirements
- R1: After reset the control word reads 0x8033 (enable and reset-enable set, interrupt-enable clear, fixed divider select 3, prescaler 0x80), and both the reload and count locations read 0x8000, with both outputs low.
- R2: Location 0 is the control word. Bit 0 is enable, bit 1 is reset-enable, bit 2 is interrupt-enable, bits 5:4 are the fixed divider select and bits 15:8 are the prescaler. Other bits read 0. Location 1 is the reload value and location 2 is the count. Each reads back what was written.
- R3: A write to location 2 loads the counter in the same clock edge, whether or not the timer is enabled.
- R4: With prescaler field P, select S and count N, the timer expires (N+1)·(P+1)·(16·2^S) clock edges after the count write. The output rises on that edge.
- R5: On expiry the counter reloads from the reload location and runs on, so later expiries follow at the same spacing.
- R6: The interrupt output is high for exactly one clock per expiry, and only when interrupt-enable is set.
- R7: The reset output is high for exactly 128 clocks from expiry, and only when reset-enable is set.
- R8: With enable clear the count holds its value and neither output rises.
- R9: A count write or a control write restarts both dividers, so a keep-alive write pushes the next expiry a full period past the write.
- R10: Location 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register location |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Expiry interrupt pulse |
| rst_o | output | 1 | Expiry reset pulse |

## Verification
The timing check sweeps every combination of prescaler 0 to 3, all four divider selects and counts 0 and 1. In each case it measures the edges up to the first interrupt and then the edges between the first and second interrupt. The first number checks the product formula, so a mistake in any one factor shows up. The second number separates a correct reload from a timer that stops or starts from a stale state. Separate runs cover the reset pulse with the interrupt disabled, a keep-alive write made partway through a period, a frozen timer, and writes to the unused location.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PSC_W = 8;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    LOC_CTRL = 2'd0,
    LOC_LOAD = 2'd1,
    LOC_CNT  = 2'd2,
    LOC_NONE = 2'd3
  } loc_e;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic [1:0]       div_sel;
    logic             irq_en;
    logic             rst_en;
    logic             en;
  } ctrl_t;

  function automatic logic [REG_W-1:0] ctrl_pack(ctrl_t c);
    return {c.psc, 2'b00, c.div_sel, 1'b0, c.irq_en, c.rst_en, c.en};
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [REG_W-1:0] w);
    ctrl_t c;
    c.psc     = w[15:8];
    c.div_sel = w[5:4];
    c.irq_en  = w[2];
    c.rst_en  = w[1];
    c.en      = w[0];
    return c;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000,
  parameter logic [PSC_W-1:0] RESET_PSC = 8'h80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  loc_e             loc_i,
  input  logic [REG_W-1:0] wdata_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] load_o,
  output logic             ctrl_wr_o
);
  assign ctrl_wr_o = we_i && loc_i == LOC_CTRL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '{psc: RESET_PSC, div_sel: 2'd3, irq_en: 1'b0, rst_en: 1'b1, en: 1'b1};
      load_o <= RESET_LOAD;
    end else if (we_i) begin
      if (loc_i == LOC_CTRL) ctrl_o <= ctrl_unpack(wdata_i);
      if (loc_i == LOC_LOAD) load_o <= wdata_i[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/wdt_clkdiv.sv
module wdt_clkdiv #(
  parameter int PSC_W    = 8,
  parameter int BASE_DIV = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clear_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [1:0]       div_sel_i,
  output logic             tick_o
);
  localparam int NSEL  = 4;
  localparam int DIV_W = $clog2(BASE_DIV * (1 << (NSEL - 1)));

  logic [DIV_W-1:0] lim_tab [NSEL];
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_tab[g] = DIV_W'(BASE_DIV * (1 << g) - 1);
  end

  logic [PSC_W-1:0] psc_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             psc_tick;

  assign psc_tick = en_i && psc_cnt == psc_i;
  assign tick_o   = psc_tick && div_cnt == lim_tab[div_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_cnt <= '0;
      div_cnt <= '0;
    end else if (clear_i) begin
      psc_cnt <= '0;
      div_cnt <= '0;
    end else if (en_i) begin
      psc_cnt <= psc_tick ? '0 : psc_cnt + 1'b1;
      if (psc_tick) div_cnt <= tick_o ? '0 : div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  // a keep-alive in the expiry cycle wins over the expiry
  assign expire_o = tick_i && cnt_o == '0 && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= RESET_LOAD;
    else if (load_i)   cnt_o <= load_val_i;
    else if (expire_o) cnt_o <= reload_i;
    else if (tick_i)   cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int RST_CYCLES = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic irq_en_i,
  input  logic rst_en_i,
  output logic irq_o,
  output logic rst_o
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  logic [RW-1:0] rst_left;

  assign rst_o = rst_left != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o    <= 1'b0;
      rst_left <= '0;
    end else begin
      irq_o <= expire_i && irq_en_i;
      if (expire_i && rst_en_i) rst_left <= RW'(RST_CYCLES);
      else if (rst_o)           rst_left <= rst_left - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int BASE_DIV   = 16,
  parameter int RST_CYCLES = 128,
  parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000,
  parameter logic [PSC_W-1:0] RESET_PSC  = 8'h80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             rst_o
);
  loc_e             loc;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic             ctrl_wr, cnt_wr, tick, expire;

  assign loc    = loc_e'(addr_i);
  assign cnt_wr = we_i && loc == LOC_CNT;

  wdt_regs #(.CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD), .RESET_PSC(RESET_PSC)) u_regs (
    .clk_i, .rst_ni, .we_i, .loc_i(loc), .wdata_i,
    .ctrl_o(ctrl_q), .load_o(load_q), .ctrl_wr_o(ctrl_wr)
  );

  wdt_clkdiv #(.PSC_W(PSC_W), .BASE_DIV(BASE_DIV)) u_div (
    .clk_i, .rst_ni, .en_i(ctrl_q.en), .clear_i(ctrl_wr || cnt_wr),
    .psc_i(ctrl_q.psc), .div_sel_i(ctrl_q.div_sel), .tick_o(tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(cnt_wr),
    .load_val_i(wdata_i[CNT_W-1:0]), .reload_i(load_q),
    .cnt_o(cnt_q), .expire_o(expire)
  );

  wdt_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk_i, .rst_ni, .expire_i(expire), .irq_en_i(ctrl_q.irq_en),
    .rst_en_i(ctrl_q.rst_en), .irq_o, .rst_o
  );

  always_comb begin
    unique case (loc)
      LOC_CTRL: rdata_o = ctrl_pack(ctrl_q);
      LOC_LOAD: rdata_o = REG_W'(load_q);
      LOC_CNT:  rdata_o = REG_W'(cnt_q);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [15:0]      wdata_i,
  input logic             en,
  input logic             irq_en,
  input logic             rst_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load,
  input logic             irq_o,
  input logic             rst_o
);
  logic cnt_wr;
  assign cnt_wr = we_i && addr_i == 2'd2;

  assert_cnt_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt == $past(wdata_i[CNT_W-1:0]));

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> cnt == $past(load));

  assert_irq_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en) && $past(en));

  assert_rst_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(rst_en) && $past(en));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !cnt_wr) |=> $stable(cnt));
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
  .en(ctrl_q.en), .irq_en(ctrl_q.irq_en), .rst_en(ctrl_q.rst_en),
  .cnt(cnt_q), .load(load_q), .irq_o, .rst_o
);

// File: tb/wdt_top_test.sv
`timescale 1ns/1ps
module wdt_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, rst;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  wdt_top uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .rst_o(rst)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // edges until irq is seen high, from the current negedge
  task automatic edges_to_irq(input int limit, output int e);
    e = 0;
    while (e < limit) begin
      @(posedge clk); e++;
      @(negedge clk);
      if (irq) break;
    end
  endtask

  function automatic logic [15:0] ctl(input int psc, input int sel, input bit ie, input bit re, input bit en);
    return {8'(psc), 2'b00, 2'(sel), 1'b0, ie, re, en};
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int e, per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(2'd0, v); check("R1 ctrl", v, 16'h8033);
    rd(2'd1, v); check("R1 load", v, 16'h8000);
    rd(2'd2, v); check("R1 count", v, 16'h8000);
    check("R1 irq", irq, 0);
    check("R1 rst", rst, 0);

    // R2 map and readback
    wr(2'd0, 16'hFFFE); rd(2'd0, v); check("R2 ctrl bits", v, 16'hFF36);
    wr(2'd1, 16'h1234); rd(2'd1, v); check("R2 load", v, 16'h1234);

    // R8 frozen when disabled, R3 load while disabled
    wr(2'd0, ctl(0, 0, 1, 1, 0));
    wr(2'd2, 16'd5); rd(2'd2, v); check("R3 load while off", v, 5);
    rd(2'd0, v); check("R8 enable reads 0", v[0], 0);
    e = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (irq || rst) e++;
    end
    check("R8 no outputs", e, 0);
    rd(2'd2, v); check("R8 count held", v, 5);

    // R10 unused location
    wr(2'd3, 16'hABCD);
    rd(2'd3, v); check("R10 reads 0", v, 0);
    rd(2'd1, v); check("R10 load untouched", v, 16'h1234);
    rd(2'd0, v); check("R10 ctrl untouched", v, ctl(0, 0, 1, 1, 0));

    // R4/R5/R6 sweep
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        for (int n = 0; n < 2; n++) begin
          per = (n + 1) * (p + 1) * (16 << s);
          wr(2'd0, ctl(p, s, 1, 0, 1));
          wr(2'd1, 16'(n));
          wr(2'd2, 16'(n));
          edges_to_irq(per + 10, e);
          check($sformatf("R4 p%0d s%0d n%0d", p, s, n), e, per);
          @(posedge clk); @(negedge clk);
          check("R6 irq one cycle", irq, 0);
          edges_to_irq(per + 10, e);
          check($sformatf("R5 p%0d s%0d n%0d", p, s, n), e + 1, per);
        end

    // R9 keep-alive restarts the period
    wr(2'd0, ctl(1, 0, 1, 0, 1));
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd1);
    e = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq) e++;
    end
    wr(2'd2, 16'd1);
    check("R9 no early irq", e, 0);
    edges_to_irq(200, e);
    check("R9 period after keep-alive", e, 64);

    // R7 reset pulse, interrupt disabled
    wr(2'd0, ctl(7, 3, 0, 1, 1));
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd1);
    e = 0; per = 0;
    while (!rst && e < 3000) begin
      @(posedge clk); e++;
      @(negedge clk);
      if (irq) per++;
    end
    check("R7 rst at expiry (R4)", e, 2048);
    e = 0;
    while (rst && e < 300) begin
      e++;
      if (irq) per++;
      @(posedge clk); @(negedge clk);
    end
    check("R7 pulse length", e, 128);
    check("R6 irq masked", per, 0);
    wr(2'd0, ctl(0, 0, 0, 0, 0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule